// File: doc/BRIEF.md
# LIN Error Monitor

This block observes the traffic of one LIN node and records five kinds of protocol fault in a status byte: a sync field out of tolerance, a bad identifier parity, a timeout, a checksum mismatch and a read-back bit mismatch. It sits beside a LIN frame engine. The engine supplies one-cycle phase strobes: break seen, sync field finished, identifier received, byte received and frame finished. The engine also supplies the results of its own tolerance, parity and checksum comparisons. The monitor does no arithmetic of its own on those fields.

Four cooperating watchdogs feed the single timeout flag. The first is a frame-length timer that starts at every break. The second is a response timer that runs while the node waits for data. The third is a deadline for the application to acknowledge, or stop, before the first byte after the identifier is complete. The fourth is a timer that starts after this node sends a wakeup signal and expects a sync field before it expires. All limits count ticks of a shared prescaler, so they are set in multiples of `PRESCALE` clocks. Flags stay set until the clear strobe. Any flag drives one interrupt line. Every new fault also produces a one-cycle abort request to the frame engine.

Top module: `lin_err_monitor`

## Requirements
- R1: After reset `err_status` is 0x00, and bits 7 to 5 of `err_status` read as zero at all times.
- R2: Bit 4 of `err_status` (sync) is set when `sync_done` and `sync_tol_bad` are high together while `slave_mode` is 1; in master mode (`slave_mode` = 0) the same strobes leave it clear.
- R3: Bit 3 (parity) is set when `id_rcvd` and `parity_bad` are high together while `slave_mode` is 1; in master mode they leave it clear.
- R4: Bit 0 (bit error) is set when `bit_chk` is high and `rx_bit` differs from `tx_bit`; a matching compare leaves it clear.
- R5: Bit 1 (checksum) is set when `frame_end` and `chk_bad` are high together.
- R6: Bit 2 (timeout) is set when `FRAME_TICKS` ticks pass after `brk_det` without `frame_end`; a `frame_end` before that stops the frame timer.
- R7: In either mode, bit 2 is set when `resp_wait` stays high for `RESP_TICKS` ticks with no `byte_rcvd`; each `byte_rcvd` restarts that count, and lowering `resp_wait` stops it.
- R8: In slave mode, after an `ack_req` pulse, bit 2 is set if `byte_rcvd` arrives before either `app_ack` or `app_stop`; in master mode `ack_req` has no effect.
- R9: In slave mode, bit 2 is set when `WAKE_TICKS` ticks pass after `wake_sent` without `sync_done` or `brk_det`; a sync field in time cancels that check.
- R10: The five flags are sticky until `clr_err`; a fault in the same cycle as `clr_err` still sets its flag.
- R11: `err_irq` is high exactly when any flag is set, and `abort_frame` is a one-cycle pulse in the cycle the flag of a new fault appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1 = node is a slave, 0 = master |
| tx_bit | input | 1 | Bit the node is driving |
| rx_bit | input | 1 | Bit sampled back from the bus |
| bit_chk | input | 1 | Compare strobe for tx_bit against rx_bit |
| brk_det | input | 1 | Break detected, start of a frame |
| sync_done | input | 1 | Sync field finished |
| sync_tol_bad | input | 1 | Sync edges out of tolerance, valid with sync_done |
| id_rcvd | input | 1 | Identifier byte received |
| parity_bad | input | 1 | Identifier parity mismatch, valid with id_rcvd |
| byte_rcvd | input | 1 | A data or checksum byte received |
| frame_end | input | 1 | Frame finished |
| chk_bad | input | 1 | Checksum mismatch, valid with frame_end |
| resp_wait | input | 1 | Node is waiting for data on the bus |
| ack_req | input | 1 | Data-acknowledge request raised to the application |
| app_ack | input | 1 | Application acknowledge strobe |
| app_stop | input | 1 | Application stop strobe |
| wake_sent | input | 1 | Node finished sending a wakeup signal |
| clr_err | input | 1 | Clear all flags |
| err_status | output | 8 | Flags: bit4 sync, bit3 parity, bit2 timeout, bit1 checksum, bit0 bit error |
| err_irq | output | 1 | Any flag set |
| abort_frame | output | 1 | One-cycle request to abandon the current frame |

## Verification
The checker assumes that the qualifier inputs (`sync_tol_bad`, `parity_bad`, `chk_bad`, and the `rx_bit`/`tx_bit` pair) matter only in the cycle of their strobe. It also assumes that each phase strobe lasts exactly one clock. The stimulus therefore raises every strobe for a single cycle at the falling edge, drives its qualifier in that same cycle, and returns both to zero before the next edge. Timer scenarios sample well clear of the expiry point on both sides. This allows for the free-running prescaler, whose phase relative to each start strobe can shift expiry by up to one tick.

// File: rtl/lin_err_pkg.sv
package lin_err_pkg;
   localparam int NFLAG    = 5;
   localparam int F_BIT    = 0;
   localparam int F_CHK    = 1;
   localparam int F_TOUT   = 2;
   localparam int F_PARITY = 3;
   localparam int F_SYNC   = 4;

   typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/lin_tick_gen.sv
module lin_tick_gen #(
   parameter int PRESCALE = 1000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   if (PRESCALE < 1) begin : g_bad_pre
      $error("lin_tick_gen: PRESCALE must be at least 1");
   end

   if (PRESCALE == 1) begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tick <= 1'b0;
         else        tick <= 1'b1;
      end
   end else begin : g_div
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            div_q <= '0;
            tick  <= 1'b0;
         end else if (div_q == PW'(PRESCALE - 1)) begin
            div_q <= '0;
            tick  <= 1'b1;
         end else begin
            div_q <= div_q + 1'b1;
            tick  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/lin_tick_timer.sv
module lin_tick_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic arm,
   input  logic halt,
   output logic expire
);
   if (LIMIT < 2) begin : g_bad_lim
      $error("lin_tick_timer: LIMIT must be at least 2");
   end

   localparam int CW = $clog2(LIMIT);

   logic          run_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         cnt_q  <= '0;
         expire <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (arm) begin
            run_q <= 1'b1;
            cnt_q <= '0;
         end else if (halt) begin
            run_q <= 1'b0;
         end else if (run_q && tick) begin
            if (cnt_q == CW'(LIMIT - 1)) begin
               run_q  <= 1'b0;
               expire <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/lin_err_monitor.sv
module lin_err_monitor
   import lin_err_pkg::*;
#(
   parameter int PRESCALE    = 1000,
   parameter int FRAME_TICKS = 700,
   parameter int RESP_TICKS  = 300,
   parameter int WAKE_TICKS  = 7500
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       slave_mode,
   input  logic       tx_bit,
   input  logic       rx_bit,
   input  logic       bit_chk,
   input  logic       brk_det,
   input  logic       sync_done,
   input  logic       sync_tol_bad,
   input  logic       id_rcvd,
   input  logic       parity_bad,
   input  logic       byte_rcvd,
   input  logic       frame_end,
   input  logic       chk_bad,
   input  logic       resp_wait,
   input  logic       ack_req,
   input  logic       app_ack,
   input  logic       app_stop,
   input  logic       wake_sent,
   input  logic       clr_err,
   output logic [7:0] err_status,
   output logic       err_irq,
   output logic       abort_frame
);
   localparam int PAD = 8 - NFLAG;

   if (FRAME_TICKS <= RESP_TICKS) begin : g_bad_cfg
      $error("lin_err_monitor: FRAME_TICKS must exceed RESP_TICKS");
   end

   logic tick;
   logic frame_exp, resp_exp, wake_exp;
   logic resp_wait_q;
   logic ack_pend_q;
   logic ack_miss;
   flag_vec_t set_vec, flags_q;

   lin_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   lin_tick_timer #(.LIMIT(FRAME_TICKS)) u_frame_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .arm(brk_det), .halt(frame_end), .expire(frame_exp)
   );

   lin_tick_timer #(.LIMIT(RESP_TICKS)) u_resp_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .arm(resp_wait && (!resp_wait_q || byte_rcvd)),
      .halt(!resp_wait), .expire(resp_exp)
   );

   lin_tick_timer #(.LIMIT(WAKE_TICKS)) u_wake_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .arm(wake_sent && slave_mode), .halt(sync_done || brk_det),
      .expire(wake_exp)
   );

   // acknowledge deadline: pending from request until ack/stop or first byte
   assign ack_miss = ack_pend_q && byte_rcvd && !(app_ack || app_stop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_wait_q <= 1'b0;
         ack_pend_q  <= 1'b0;
      end else begin
         resp_wait_q <= resp_wait;
         if (ack_req && slave_mode)
            ack_pend_q <= 1'b1;
         else if (app_ack || app_stop || byte_rcvd || brk_det)
            ack_pend_q <= 1'b0;
      end
   end

   always_comb begin
      set_vec           = '0;
      set_vec[F_BIT]    = bit_chk && (tx_bit != rx_bit);
      set_vec[F_CHK]    = frame_end && chk_bad;
      set_vec[F_TOUT]   = frame_exp || resp_exp || wake_exp || ack_miss;
      set_vec[F_PARITY] = slave_mode && id_rcvd && parity_bad;
      set_vec[F_SYNC]   = slave_mode && sync_done && sync_tol_bad;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q     <= '0;
         abort_frame <= 1'b0;
      end else begin
         flags_q     <= (clr_err ? '0 : flags_q) | set_vec;
         abort_frame <= |set_vec;
      end
   end

   assign err_status = {{PAD{1'b0}}, flags_q};
   assign err_irq    = |flags_q;
endmodule

// File: rtl/lin_err_monitor_chk.sv
module lin_err_monitor_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       slave_mode,
   input logic       tx_bit,
   input logic       rx_bit,
   input logic       bit_chk,
   input logic       id_rcvd,
   input logic       frame_end,
   input logic       chk_bad,
   input logic       clr_err,
   input logic [7:0] err_status,
   input logic       err_irq,
   input logic       abort_frame
);
   // R1
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_status[7:5] == 3'b000);

   // R2
   sync_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave_mode && !err_status[4]) |=> !err_status[4]);

   // R3
   parity_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave_mode && !err_status[3]) |=> !err_status[3]);

   // R3
   parity_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!id_rcvd && !err_status[3]) |=> !err_status[3]);

   // R4
   bit_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_chk && (tx_bit != rx_bit)) |=> err_status[0]);

   // R5
   chk_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && chk_bad) |=> err_status[1]);

   // R10
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_err |=> ((err_status & $past(err_status)) == $past(err_status)));

   // R11
   abort_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_frame |-> err_irq);

   // R11
   irq_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_irq == (err_status != 8'h00));
endmodule

bind lin_err_monitor lin_err_monitor_chk u_chk (
   .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
   .tx_bit(tx_bit), .rx_bit(rx_bit), .bit_chk(bit_chk),
   .id_rcvd(id_rcvd), .frame_end(frame_end), .chk_bad(chk_bad),
   .clr_err(clr_err), .err_status(err_status), .err_irq(err_irq),
   .abort_frame(abort_frame)
);

// File: tb/sim_lin_err_monitor.sv
`timescale 1ns/1ps
module sim_lin_err_monitor;
   localparam int PRE = 4, FRM = 20, RSP = 8, WAK = 30;

   logic clk = 1'b0, rst_n = 1'b0;
   logic slave_mode = 1'b1, tx_bit = 1'b0, rx_bit = 1'b0, bit_chk = 1'b0;
   logic brk_det = 1'b0, sync_done = 1'b0, sync_tol_bad = 1'b0;
   logic id_rcvd = 1'b0, parity_bad = 1'b0, byte_rcvd = 1'b0;
   logic frame_end = 1'b0, chk_bad = 1'b0, resp_wait = 1'b0;
   logic ack_req = 1'b0, app_ack = 1'b0, app_stop = 1'b0;
   logic wake_sent = 1'b0, clr_err = 1'b0;
   logic [7:0] err_status;
   logic err_irq, abort_frame;
   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   lin_err_monitor #(.PRESCALE(PRE), .FRAME_TICKS(FRM),
                     .RESP_TICKS(RSP), .WAKE_TICKS(WAK)) u0 (.*);

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic clear();
      clr_err = 1'b1; wait_clk(1); clr_err = 1'b0; wait_clk(1);
   endtask

   task automatic t_reset();
      check("R1 reset status", err_status, 8'h00);
      check("R11 reset irq", {7'd0, err_irq}, 8'h00);
   endtask

   task automatic t_sync_parity();
      slave_mode = 1'b0;
      sync_done = 1'b1; sync_tol_bad = 1'b1; id_rcvd = 1'b1; parity_bad = 1'b1;
      wait_clk(1);
      sync_done = 1'b0; sync_tol_bad = 1'b0; id_rcvd = 1'b0; parity_bad = 1'b0;
      check("R2 R3 master ignores sync/parity", err_status, 8'h00);
      slave_mode = 1'b1;
      sync_done = 1'b1; sync_tol_bad = 1'b1;
      wait_clk(1);
      sync_done = 1'b0; sync_tol_bad = 1'b0;
      check("R2 slave sync error", err_status, 8'h10);
      check("R11 abort pulse", {7'd0, abort_frame}, 8'h01);
      wait_clk(1);
      check("R11 abort one cycle", {7'd0, abort_frame}, 8'h00);
      check("R11 irq held", {7'd0, err_irq}, 8'h01);
      id_rcvd = 1'b1; parity_bad = 1'b1;
      wait_clk(1);
      id_rcvd = 1'b0; parity_bad = 1'b0;
      check("R3 slave parity error", err_status, 8'h18);
      check("R1 upper bits zero", err_status & 8'hE0, 8'h00);
      clear();
      check("R10 clear", err_status, 8'h00);
   endtask

   task automatic t_bit_chk();
      tx_bit = 1'b1; rx_bit = 1'b1; bit_chk = 1'b1;
      wait_clk(1);
      bit_chk = 1'b0;
      check("R4 matching bit", err_status, 8'h00);
      rx_bit = 1'b0; bit_chk = 1'b1;
      wait_clk(1);
      bit_chk = 1'b0;
      check("R4 bit mismatch", err_status, 8'h01);
      wait_clk(20);
      check("R10 sticky", err_status, 8'h01);
      frame_end = 1'b1; chk_bad = 1'b1;
      wait_clk(1);
      frame_end = 1'b0; chk_bad = 1'b0;
      check("R5 checksum error", err_status, 8'h03);
      clear();
      clr_err = 1'b1; bit_chk = 1'b1;
      wait_clk(1);
      clr_err = 1'b0; bit_chk = 1'b0;
      check("R10 set wins over clear", err_status, 8'h01);
      clear();
      rx_bit = 1'b1;
   endtask

   task automatic t_frame();
      brk_det = 1'b1; wait_clk(1); brk_det = 1'b0;
      wait_clk(FRM*PRE - 10);
      check("R6 no early frame timeout", err_status, 8'h00);
      wait_clk(20);
      check("R6 frame timeout", err_status, 8'h04);
      clear();
      brk_det = 1'b1; wait_clk(1); brk_det = 1'b0;
      wait_clk(40);
      frame_end = 1'b1; wait_clk(1); frame_end = 1'b0;
      wait_clk(FRM*PRE);
      check("R6 frame_end stops timer", err_status, 8'h00);
   endtask

   task automatic t_resp();
      slave_mode = 1'b0;
      resp_wait = 1'b1;
      wait_clk(RSP*PRE - 8);
      byte_rcvd = 1'b1; wait_clk(1); byte_rcvd = 1'b0;
      wait_clk(RSP*PRE - 8);
      check("R7 byte restarts response timer", err_status, 8'h00);
      wait_clk(16);
      check("R7 master response timeout", err_status, 8'h04);
      resp_wait = 1'b0;
      clear();
      resp_wait = 1'b1; wait_clk(10); resp_wait = 1'b0;
      wait_clk(RSP*PRE + 10);
      check("R7 lowering wait stops timer", err_status, 8'h00);
      slave_mode = 1'b1;
   endtask

   task automatic t_ack();
      ack_req = 1'b1; wait_clk(1); ack_req = 1'b0;
      wait_clk(3);
      byte_rcvd = 1'b1; wait_clk(1); byte_rcvd = 1'b0;
      check("R8 missing acknowledge", err_status, 8'h04);
      clear();
      ack_req = 1'b1; wait_clk(1); ack_req = 1'b0;
      app_ack = 1'b1; wait_clk(1); app_ack = 1'b0;
      byte_rcvd = 1'b1; wait_clk(1); byte_rcvd = 1'b0;
      check("R8 acknowledge in time", err_status, 8'h00);
      ack_req = 1'b1; wait_clk(1); ack_req = 1'b0;
      app_stop = 1'b1; wait_clk(1); app_stop = 1'b0;
      byte_rcvd = 1'b1; wait_clk(1); byte_rcvd = 1'b0;
      check("R8 stop in time", err_status, 8'h00);
      slave_mode = 1'b0;
      ack_req = 1'b1; wait_clk(1); ack_req = 1'b0;
      byte_rcvd = 1'b1; wait_clk(1); byte_rcvd = 1'b0;
      check("R8 master ignores ack_req", err_status, 8'h00);
      slave_mode = 1'b1;
   endtask

   task automatic t_wake();
      wake_sent = 1'b1; wait_clk(1); wake_sent = 1'b0;
      wait_clk(WAK*PRE - 20);
      sync_done = 1'b1; wait_clk(1); sync_done = 1'b0;
      wait_clk(60);
      check("R9 sync cancels wake timer", err_status, 8'h00);
      wake_sent = 1'b1; wait_clk(1); wake_sent = 1'b0;
      wait_clk(WAK*PRE - 10);
      check("R9 no early wake timeout", err_status, 8'h00);
      wait_clk(20);
      check("R9 wake timeout", err_status, 8'h04);
      clear();
   endtask

   initial begin
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(2);
      t_reset();
      t_sync_parity();
      t_bit_chk();
      t_frame();
      t_resp();
      t_ack();
      t_wake();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule